// File: doc/BRIEF.md
# Masked Block-Write Column Engine

This block sits on the random-access write path of a memory whose words are four bits wide. A single-cycle command interface selects one of several write types. A plain write stores four bits into one column. A masked write changes only the bit positions that a stored mask allows. A block write copies a stored colour nibble into any subset of four neighbouring columns in one cycle. A masked block write does the same, but only in the allowed bit positions. Two load commands set the colour register and the persistent mask register. Once loaded, each register stays in force until it is loaded again.

The decoded result is a registered, lane-major vector of per-column, per-bit write enables, with the matching data and the index of the aligned four-column group. A column array model inside the block consumes these enables. It has a combinational read port, so the stored contents can be observed. A command presented before clock edge N appears on the enable outputs after edge N. The array contents change at edge N+1.

Top module: `bwe_engine`

## Requirements
- R1: After reset the enable outputs are all zero, every array column reads 0, the mask register is 4'hF and the colour register is 4'h0.
- R2: A plain write (op 3'd1) enables all four bits of the lane given by the two low column bits, regardless of the mask. The enable and data vectors are lane-major, with bit index lane*4+bit. The group index on the outputs is the column address shifted right by two.
- R3: A masked write (op 3'd2) enables only the bit positions where the mask register holds 1. Disabled bits of the column keep their stored value.
- R4: The mask register keeps gating every later masked write until it is reloaded, without any new mask data being supplied.
- R5: A block write (op 3'd3) ignores the two low column bits. It writes the colour register into column group*4+i for every i whose command-data bit i is 1, so up to 16 bits are written in one cycle.
- R6: A masked block write (op 3'd4) enables the bits given by the column selection AND the mask register. All other bits keep their stored value.
- R7: Load-colour (op 3'd5) and load-mask (op 3'd6) take the command data at the next clock edge. A write issued in the cycle before a load uses the old value. A write issued in the cycle after a load uses the new value.
- R8: Load commands, no-op (op 3'd0) and the reserved code 3'd7 produce no enables and leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command code (0 none, 1 write, 2 masked write, 3 block write, 4 masked block write, 5 load colour, 6 load mask) |
| cmd_col | input | COL_W (6) | Column address |
| cmd_data | input | DW (4) | Write data, column-select pattern for block writes, or load value |
| wr_en | output | DW*DW (16) | Per-lane, per-bit write enables, lane-major |
| wr_data | output | DW*DW (16) | Per-lane write data, lane-major |
| wr_grp | output | COL_W-2 (4) | Aligned four-column group index |
| rd_col | input | COL_W (6) | Array read column |
| rd_data | output | DW (4) | Array contents at rd_col |

## Verification
A register load and a write that was issued just before it fall into the same clock edge. At that edge the write's enables are being registered while the colour or mask register takes its new value. The bench provokes this by issuing a masked write followed at once by a load-mask command, and a block write followed at once by a load-colour command. It also issues the reverse orders. The result is judged from the array contents read back through the read port. The write issued before the load must carry the old register value, and the write issued after it must carry the new one.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WR    = 3'd1,
        OP_MWR   = 3'd2,
        OP_BLK   = 3'd3,
        OP_MBLK  = 3'd4,
        OP_LDCOL = 3'd5,
        OP_LDMSK = 3'd6,
        OP_RSVD  = 3'd7
    } bwe_op_e;
endpackage

// File: rtl/bwe_regs.sv
module bwe_regs #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] colour_q,
    output logic [DW-1:0] mask_q
);
    import bwe_pkg::*;

    typedef struct packed {
        logic [DW-1:0] colour;
        logic [DW-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bwe_op_e'(op) == OP_LDCOL) st_d.colour = din;
        if (bwe_op_e'(op) == OP_LDMSK) st_d.mask   = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.colour <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign colour_q = st_q.colour;
    assign mask_q   = st_q.mask;
endmodule

// File: rtl/bwe_lanes.sv
module bwe_lanes #(
    parameter int DW     = 4,
    parameter int LANE_W = 2
) (
    input  logic [2:0]       op,
    input  logic [LANE_W-1:0] lane,
    input  logic [DW-1:0]    din,
    input  logic [DW-1:0]    colour,
    input  logic [DW-1:0]    mask,
    output logic [DW*DW-1:0] en_d,
    output logic [DW*DW-1:0] data_d
);
    import bwe_pkg::*;

    for (genvar l = 0; l < DW; l++) begin : g_lane
        logic          sel;
        logic [DW-1:0] bits;
        logic [DW-1:0] val;
        always_comb begin
            sel  = 1'b0;
            bits = '1;
            val  = din;
            case (bwe_op_e'(op))
                OP_WR:   begin sel = (lane == LANE_W'(l)); bits = '1;   val = din;    end
                OP_MWR:  begin sel = (lane == LANE_W'(l)); bits = mask; val = din;    end
                OP_BLK:  begin sel = din[l];               bits = '1;   val = colour; end
                OP_MBLK: begin sel = din[l];               bits = mask; val = colour; end
                default: begin sel = 1'b0;                 bits = '1;   val = din;    end
            endcase
        end
        assign en_d[l*DW +: DW]   = sel ? bits : '0;
        assign data_d[l*DW +: DW] = val;
    end
endmodule

// File: rtl/bwe_array.sv
module bwe_array #(
    parameter int DW    = 4,
    parameter int COL_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DW*DW-1:0]       wr_en,
    input  logic [DW*DW-1:0]       wr_data,
    input  logic [COL_W-$clog2(DW)-1:0] wr_grp,
    input  logic [COL_W-1:0]       rd_col,
    output logic [DW-1:0]          rd_data
);
    localparam int COLS   = 1 << COL_W;
    localparam int LANE_W = $clog2(DW);

    logic [DW-1:0] mem_d [COLS];
    logic [DW-1:0] mem_q [COLS];

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            logic [COL_W-1:0]  cidx;
            logic [LANE_W-1:0] ln;
            cidx     = COL_W'(c);
            ln       = cidx[LANE_W-1:0];
            mem_d[c] = mem_q[c];
            if (cidx[COL_W-1:LANE_W] == wr_grp) begin
                for (int b = 0; b < DW; b++) begin
                    if (wr_en[int'(ln)*DW + b]) mem_d[c][b] = wr_data[int'(ln)*DW + b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) mem_q[c] <= '0;
        end else begin
            for (int c = 0; c < COLS; c++) mem_q[c] <= mem_d[c];
        end
    end

    assign rd_data = mem_q[rd_col];
endmodule

// File: rtl/bwe_engine.sv
module bwe_engine #(
    parameter int DW    = 4,
    parameter int COL_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    cmd_op,
    input  logic [COL_W-1:0]              cmd_col,
    input  logic [DW-1:0]                 cmd_data,
    output logic [DW*DW-1:0]              wr_en,
    output logic [DW*DW-1:0]              wr_data,
    output logic [COL_W-$clog2(DW)-1:0]   wr_grp,
    input  logic [COL_W-1:0]              rd_col,
    output logic [DW-1:0]                 rd_data
);
    localparam int LANE_W = $clog2(DW);
    localparam int GRP_W  = COL_W - LANE_W;
    localparam int NB     = DW * DW;

    typedef struct packed {
        logic [NB-1:0]    en;
        logic [NB-1:0]    data;
        logic [GRP_W-1:0] grp;
    } out_t;

    logic [DW-1:0] colour_q, mask_q;
    logic [NB-1:0] en_c, data_c;
    out_t          out_d, out_q;

    bwe_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (cmd_op),
        .din      (cmd_data),
        .colour_q (colour_q),
        .mask_q   (mask_q)
    );

    bwe_lanes #(.DW(DW), .LANE_W(LANE_W)) u_lanes (
        .op     (cmd_op),
        .lane   (cmd_col[LANE_W-1:0]),
        .din    (cmd_data),
        .colour (colour_q),
        .mask   (mask_q),
        .en_d   (en_c),
        .data_d (data_c)
    );

    always_comb begin
        out_d      = out_q;
        out_d.en   = en_c;
        out_d.data = data_c;
        out_d.grp  = cmd_col[COL_W-1:LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wr_en   = out_q.en;
    assign wr_data = out_q.data;
    assign wr_grp  = out_q.grp;

    bwe_array #(.DW(DW), .COL_W(COL_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (out_q.en),
        .wr_data (out_q.data),
        .wr_grp  (out_q.grp),
        .rd_col  (rd_col),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/bwe_chk.sv
module bwe_chk #(
    parameter int DW    = 4,
    parameter int COL_W = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [2:0]                  cmd_op,
    input logic [COL_W-1:0]            cmd_col,
    input logic [DW-1:0]               cmd_data,
    input logic [DW*DW-1:0]            wr_en,
    input logic [COL_W-$clog2(DW)-1:0] wr_grp
);
    localparam int LANE_W = $clog2(DW);
    localparam int NB     = DW * DW;
    localparam logic [NB-1:0] ONE_LANE = NB'({DW{1'b1}});

    logic          live_q;
    logic [DW-1:0] lane_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    for (genvar l = 0; l < DW; l++) begin : g_any
        assign lane_any[l] = |wr_en[l*DW +: DW];
    end

    // R8
    quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(cmd_op) == 3'd0 || $past(cmd_op) >= 3'd5)) |-> (wr_en == '0));

    // R2
    single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(cmd_op) == 3'd1) |->
        (wr_en == (ONE_LANE << (DW * $past(cmd_col[LANE_W-1:0]))) &&
         wr_grp == $past(cmd_col[COL_W-1:LANE_W])));

    // R3
    masked_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(cmd_op) == 3'd2) |-> ($countones(wr_en) <= DW && $onehot0(lane_any)));

    // R5
    block_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(cmd_op) == 3'd3) |-> (lane_any == $past(cmd_data)));

    // R6
    mblock_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(cmd_op) == 3'd4) |-> ((lane_any & ~$past(cmd_data)) == '0));
endmodule

bind bwe_engine bwe_chk #(.DW(DW), .COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_op   (cmd_op),
    .cmd_col  (cmd_col),
    .cmd_data (cmd_data),
    .wr_en    (wr_en),
    .wr_grp   (wr_grp)
);

// File: tb/tb_bwe_engine.sv
`timescale 1ns/1ps
module tb_bwe_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [5:0]  cmd_col = '0;
    logic [3:0]  cmd_data = '0;
    logic [15:0] wr_en, wr_data;
    logic [3:0]  wr_grp;
    logic [5:0]  rd_col = '0;
    logic [3:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bwe_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_col(cmd_col),
        .cmd_data(cmd_data), .wr_en(wr_en), .wr_data(wr_data),
        .wr_grp(wr_grp), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the capturing edge
    task automatic cmd(input logic [2:0] op, input logic [5:0] col, input logic [3:0] d);
        cmd_op = op; cmd_col = col; cmd_data = d;
        @(negedge clk);
        cmd_op = 3'd0; cmd_col = '0; cmd_data = '0;
    endtask

    task automatic idle();
        cmd(3'd0, 6'd0, 4'd0);
    endtask

    task automatic peek(input string req, input logic [5:0] col, input logic [3:0] exp);
        rd_col = col;
        #1;
        check(req, {12'd0, rd_data}, {12'd0, exp});
    endtask

    task automatic t_reset();
        check("R1 enables", wr_en, 16'h0000);
        peek("R1 col0", 6'd0, 4'h0);
        peek("R1 col63", 6'd63, 4'h0);
        cmd(3'd1, 6'd40, 4'hF); idle();
        peek("R1 pre", 6'd40, 4'hF);
        cmd(3'd3, 6'd40, 4'h1); idle();
        peek("R1 colour zero", 6'd40, 4'h0);
        cmd(3'd2, 6'd41, 4'hB); idle();
        peek("R1 mask ones", 6'd41, 4'hB);
    endtask

    task automatic t_normal();
        cmd(3'd6, 6'd0, 4'h3); idle();
        cmd(3'd1, 6'd5, 4'hA);
        check("R2 enables", wr_en, 16'h00F0);
        check("R2 data lane", {12'd0, wr_data[7:4]}, 16'h000A);
        check("R2 group", {12'd0, wr_grp}, 16'h0001);
        idle();
        peek("R2 mask ignored", 6'd5, 4'hA);
    endtask

    task automatic t_masked();
        cmd(3'd2, 6'd5, 4'h5);
        check("R3 enables", wr_en, 16'h0030);
        idle();
        peek("R3 masked merge", 6'd5, 4'h9);
        cmd(3'd2, 6'd5, 4'h6); idle();
        peek("R4 mask persists", 6'd5, 4'hA);
    endtask

    task automatic t_block();
        cmd(3'd5, 6'd0, 4'hC); idle();
        cmd(3'd3, 6'd14, 4'hB);
        check("R5 enables", wr_en, 16'hF0FF);
        check("R5 group aligned", {12'd0, wr_grp}, 16'h0003);
        idle();
        peek("R5 col12", 6'd12, 4'hC);
        peek("R5 col13", 6'd13, 4'hC);
        peek("R5 col14 unselected", 6'd14, 4'h0);
        peek("R5 col15", 6'd15, 4'hC);
        cmd(3'd3, 6'd17, 4'hF);
        check("R5 sixteen bits", wr_en, 16'hFFFF);
        idle();
        for (int c = 16; c < 20; c++) peek("R5 full group", 6'(c), 4'hC);
    endtask

    task automatic t_mblock();
        cmd(3'd6, 6'd0, 4'h6); idle();
        cmd(3'd5, 6'd0, 4'h3); idle();
        cmd(3'd4, 6'd16, 4'h5);
        check("R6 enables", wr_en, 16'h0606);
        idle();
        peek("R6 col16", 6'd16, 4'hA);
        peek("R6 col17", 6'd17, 4'hC);
        peek("R6 col18", 6'd18, 4'hA);
        peek("R6 col19", 6'd19, 4'hC);
    endtask

    task automatic t_order();
        cmd(3'd2, 6'd20, 4'hF);
        cmd(3'd6, 6'd0, 4'h9);
        cmd(3'd2, 6'd21, 4'hF);
        idle();
        peek("R7 old mask", 6'd20, 4'h6);
        peek("R7 new mask", 6'd21, 4'h9);
        cmd(3'd5, 6'd0, 4'h5);
        cmd(3'd3, 6'd24, 4'h1);
        cmd(3'd3, 6'd28, 4'h1);
        cmd(3'd5, 6'd0, 4'hA);
        idle();
        peek("R7 new colour", 6'd24, 4'h5);
        peek("R7 old colour", 6'd28, 4'h5);
    endtask

    task automatic t_quiet();
        cmd(3'd6, 6'd5, 4'h0);
        check("R8 load no enable", wr_en, 16'h0000);
        cmd(3'd7, 6'd5, 4'h0);
        check("R8 reserved no enable", wr_en, 16'h0000);
        cmd(3'd0, 6'd5, 4'h0);
        check("R8 none no enable", wr_en, 16'h0000);
        idle();
        peek("R8 array kept", 6'd5, 4'hA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_masked();
        t_block();
        t_mblock();
        t_order();
        t_quiet();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule